// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the processor-facing side of a two-channel asynchronous serial controller. A byte-wide memory-mapped bus with separate read and write strobes reaches, for each channel, a pair of mode registers behind a pointer that advances once, a write-only command register, a status register, and receive and transmit holding registers. A clock-select byte is stored per channel. Shared logic holds an interrupt mask, reports an interrupt status word and drives a general-purpose output port. The port is changed only through a set address and a clear address. Bit-serial shifting and baud generation are left to separate engines.

Toward each channel's engines the block exposes two valid/ready byte streams. Transmit: `tx_valid` rises when a byte sits in the transmit holding register and the transmitter is enabled. `tx_valid` and `tx_data` hold steady until the engine raises `tx_ready`. The handshake cycle empties the holding register. Receive: `rx_ready` equals the receiver enable. While `rx_ready` is high, every `rx_valid` cycle is taken. A byte that arrives while the holding register is still full, and is not being read in that cycle, is dropped and sets the overrun flag. Back-pressure toward the receive engine is therefore only the enable.

The bus uses bits [5:2] of the address as a word index, and bits [1:0] are ignored. Read data is combinational while `bus_rd` is high. Read side effects, such as emptying the receive holding register or advancing the mode pointer, take place at the clock edge that ends the read cycle.

Top module: `duart_regif`

## Requirements
- R1: After reset, both status registers read 0x00, `irq` is 0, `out_port` is 0x00, `tx_valid` and `brk_out` are 0, and every mode and clock-select register is 0x00.
- R2: A write to the command register (channel offset 0x08) acts on its low nibble in the same write as its command field. Bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When both bits of a pair are set, disable wins. Once enabled with nothing queued and `tx_busy` low, the status register reads 0x0C.
- R3: The status register (read at offset 0x04) uses these bits: 7 break, 6 framing error, 5 parity error, 4 overrun, 3 transmitter empty, 2 transmitter ready, 0 receiver ready. Transmitter ready is 1 when the transmitter is enabled and the holding register is free. Transmitter empty is 1 when transmitter ready is 1 and `tx_busy` is low.
- R4: A write to offset 0x0C while the transmitter is ready loads the holding register and raises `tx_valid` with that byte. `tx_valid` and `tx_data` stay unchanged until the `tx_ready` handshake. A write while the holding register is full is ignored.
- R5: Command field [6:4] = 3 resets the transmitter. It drops any pending byte, so `tx_valid` falls and the status register reads transmitter ready and empty again.
- R6: A received byte sets receiver ready. Its break, framing and parity flags (`rx_flags` bits 2, 1, 0) are latched with it into status bits 7, 6 and 5. Reading offset 0x0C returns the byte and clears receiver ready and those three flags.
- R7: A byte that arrives while the receive holding register is full is dropped and sets overrun. Overrun survives the read of the held byte. Command code 2 clears receiver ready, the error flags and overrun.
- R8: While the receiver is disabled, `rx_ready` is 0 and incoming bytes change no status bit.
- R9: After command code 1, the first access to offset 0x00 (read or write) addresses mode register 1 and every later access addresses mode register 2, until the next code 1.
- R10: A write to offset 0x04 stores the clock-select byte on `csel_q` and does not alter the status register.
- R11: The interrupt status register reads at 0x14 and the mask register is written at 0x14. Bit 0 is channel A transmitter ready, bit 1 channel A receiver ready, bit 4 channel B transmitter ready and bit 5 channel B receiver ready. `irq` is 1 exactly when status AND mask is nonzero.
- R12: A write at 0x38 sets the `out_port` bits given as ones. A write at 0x3C clears the bits given as ones. Zero bits leave the port unchanged.
- R13: Command code 6 raises the channel's `brk_out` and code 7 lowers it. The other channel's `brk_out` is not affected.
- R14: Channel A registers sit at 0x00..0x0C and channel B repeats them at 0x20..0x2C. A write to one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address, bits [5:2] decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| out_port | output | 8 | General-purpose output port |
| tx_valid | output | 2 | Per channel: transmit byte offered |
| tx_ready | input | 2 | Per channel: transmit engine takes byte |
| tx_data | output | 2x8 | Per channel: transmit byte |
| tx_busy | input | 2 | Per channel: engine still shifting |
| rx_valid | input | 2 | Per channel: received byte offered |
| rx_ready | output | 2 | Per channel: receiver enabled |
| rx_data | input | 2x8 | Per channel: received byte |
| rx_flags | input | 2x3 | Per channel: {break, framing, parity} with the byte |
| brk_out | output | 2 | Per channel: send break |
| mode1_q | output | 2x8 | Per channel: mode register 1 |
| mode2_q | output | 2x8 | Per channel: mode register 2 |
| csel_q | output | 2x8 | Per channel: clock-select value |

## Verification
The transmit path is tried in three cases: with the engine stalled, so that back-pressure and the ignored second write can be seen; with the engine busy after the handshake, so that transmitter ready and transmitter empty separate; and with a reset while a byte is pending. The receive path is fed single bytes with each error flag, two bytes without an intervening read to force an overrun that must outlive the read, and a byte while disabled. The mode pointer is exercised by writes and by reads after a pointer reset, to tell apart a pointer that advances once from one that toggles or never moves. Interrupt tests mix masks that select ready and not-ready sources on both channels.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 6;
  localparam int IRQ_STRIDE = 4;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam logic [3:0] SH_IRQ = 4'b0101;
  localparam logic [3:0] SH_SET = 4'b1110;
  localparam logic [3:0] SH_CLR = 4'b1111;

  typedef enum logic [2:0] {
    MC_NONE    = 3'd0,
    MC_PTR_RST = 3'd1,
    MC_RX_RST  = 3'd2,
    MC_TX_RST  = 3'd3,
    MC_RSV4    = 3'd4,
    MC_RSV5    = 3'd5,
    MC_BRK_ON  = 3'd6,
    MC_BRK_OFF = 3'd7
  } misc_cmd_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_err_t;
endpackage

// File: rtl/duart_chan.sv
module duart_chan
  import duart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              sel_rd,
  input  logic [1:0]        reg_idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              txrdy_o,
  output logic              rxrdy_o,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_busy,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [2:0]        rx_flags,
  output logic              brk_o,
  output logic [BYTE_W-1:0] mode1_q,
  output logic [BYTE_W-1:0] mode2_q,
  output logic [BYTE_W-1:0] csel_q
);
  logic rx_en, tx_en, mptr, tx_full, rx_full, ovr;
  logic [BYTE_W-1:0] tx_hold, rx_hold;
  rx_err_t err_q;
  misc_cmd_e cmd;

  logic wr_mode, wr_csel, wr_cmd, wr_data, rd_mode, rd_data;
  logic tx_fire, rx_fire, txemt;

  assign cmd     = misc_cmd_e'(wdata[6:4]);
  assign wr_mode = sel_wr && reg_idx == REG_MODE;
  assign wr_csel = sel_wr && reg_idx == REG_STAT;
  assign wr_cmd  = sel_wr && reg_idx == REG_CMD;
  assign wr_data = sel_wr && reg_idx == REG_DATA;
  assign rd_mode = sel_rd && reg_idx == REG_MODE;
  assign rd_data = sel_rd && reg_idx == REG_DATA;

  assign tx_valid = tx_full && tx_en;
  assign tx_data  = tx_hold;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_ready = rx_en;
  assign rx_fire  = rx_valid && rx_en;

  assign txrdy_o = tx_en && !tx_full;
  assign txemt   = txrdy_o && !tx_busy;
  assign rxrdy_o = rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0; tx_en <= 1'b0; mptr <= 1'b0; brk_o <= 1'b0;
      mode1_q <= '0; mode2_q <= '0; csel_q <= '0;
    end else begin
      if (wr_cmd) begin
        if (wdata[0]) rx_en <= 1'b1;
        if (wdata[1]) rx_en <= 1'b0;
        if (wdata[2]) tx_en <= 1'b1;
        if (wdata[3]) tx_en <= 1'b0;
        if (cmd == MC_BRK_ON)  brk_o <= 1'b1;
        if (cmd == MC_BRK_OFF) brk_o <= 1'b0;
      end
      if (wr_cmd && cmd == MC_PTR_RST) mptr <= 1'b0;
      else if (wr_mode || rd_mode)     mptr <= 1'b1;
      if (wr_mode) begin
        if (!mptr) mode1_q <= wdata;
        else       mode2_q <= wdata;
      end
      if (wr_csel) csel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0; tx_hold <= '0;
    end else if (wr_cmd && cmd == MC_TX_RST) begin
      tx_full <= 1'b0;
    end else if (tx_fire) begin
      tx_full <= 1'b0;
    end else if (wr_data && txrdy_o) begin
      tx_full <= 1'b1;
      tx_hold <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0; rx_hold <= '0; err_q <= '0; ovr <= 1'b0;
    end else if (wr_cmd && cmd == MC_RX_RST) begin
      rx_full <= 1'b0; err_q <= '0; ovr <= 1'b0;
    end else begin
      if (rx_fire && (!rx_full || rd_data)) begin
        rx_full <= 1'b1;
        rx_hold <= rx_data;
        err_q   <= rx_err_t'(rx_flags);
      end else if (rd_data) begin
        rx_full <= 1'b0;
        err_q   <= '0;
      end
      if (rx_fire && rx_full && !rd_data) ovr <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_idx)
      REG_MODE: rdata = mptr ? mode2_q : mode1_q;
      REG_STAT: rdata = {err_q.brk, err_q.fe, err_q.pe, ovr, txemt, txrdy_o, 1'b0, rx_full};
      REG_DATA: rdata = rx_hold;
      default:  rdata = '0;
    endcase
  end

  // R4: an offered byte is held until taken
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_cmd) |=> (tx_valid && $stable(tx_data)));

  // R6: reading the held byte empties the receive holding register
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rxrdy_o && !rx_fire) |=> !rxrdy_o);

  // R7: a byte arriving on a full holding register raises overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rxrdy_o && !rd_data && !wr_cmd) |=> rdata[4] || reg_idx != REG_STAT || ovr);

  // R9: the first mode access after a pointer reset lands in mode register 1
  a_r9_first_mr1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !mptr) |=> (mode1_q == $past(wdata) && $stable(mode2_q)));
endmodule

// File: rtl/duart_shared.sv
module duart_shared
  import duart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_imr,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NUM_CH-1:0] txrdy,
  input  logic [NUM_CH-1:0] rxrdy,
  output logic [BYTE_W-1:0] isr,
  output logic              irq,
  output logic [BYTE_W-1:0] out_port
);
  logic [BYTE_W-1:0] imr;

  always_comb begin
    isr = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      isr[IRQ_STRIDE*c]     = txrdy[c];
      isr[IRQ_STRIDE*c + 1] = rxrdy[c];
    end
  end

  assign irq = |(isr & imr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr <= '0; out_port <= '0;
    end else begin
      if (wr_imr) imr <= wdata;
      if (wr_set) out_port <= out_port | wdata;
      else if (wr_clr) out_port <= out_port & ~wdata;
    end
  end

  // R12: set address forces the selected bits high
  a_r12_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_port & $past(wdata)) == $past(wdata)));
  // R12: clear address forces the selected bits low
  a_r12_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((out_port & $past(wdata)) == '0));
  // R12: the port moves only on a set or clear write
  a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(out_port));
endmodule

// File: rtl/duart_regif.sv
module duart_regif
  import duart_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [BYTE_W-1:0]             bus_wdata,
  output logic [BYTE_W-1:0]             bus_rdata,
  output logic                          irq,
  output logic [BYTE_W-1:0]             out_port,
  output logic [NUM_CH-1:0]             tx_valid,
  input  logic [NUM_CH-1:0]             tx_ready,
  output logic [NUM_CH-1:0][BYTE_W-1:0] tx_data,
  input  logic [NUM_CH-1:0]             tx_busy,
  input  logic [NUM_CH-1:0]             rx_valid,
  output logic [NUM_CH-1:0]             rx_ready,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] rx_data,
  input  logic [NUM_CH-1:0][2:0]        rx_flags,
  output logic [NUM_CH-1:0]             brk_out,
  output logic [NUM_CH-1:0][BYTE_W-1:0] mode1_q,
  output logic [NUM_CH-1:0][BYTE_W-1:0] mode2_q,
  output logic [NUM_CH-1:0][BYTE_W-1:0] csel_q
);
  logic [3:0] widx;
  logic       is_shared;
  logic [NUM_CH-1:0] txrdy, rxrdy;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;
  logic [BYTE_W-1:0] isr;

  assign widx      = bus_addr[5:2];
  assign is_shared = bus_addr[4];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = !is_shared && (bus_addr[5] == c[0]);
    duart_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (bus_wr && hit),
      .sel_rd   (bus_rd && hit),
      .reg_idx  (bus_addr[3:2]),
      .wdata    (bus_wdata),
      .rdata    (ch_rdata[c]),
      .txrdy_o  (txrdy[c]),
      .rxrdy_o  (rxrdy[c]),
      .tx_valid (tx_valid[c]),
      .tx_ready (tx_ready[c]),
      .tx_data  (tx_data[c]),
      .tx_busy  (tx_busy[c]),
      .rx_valid (rx_valid[c]),
      .rx_ready (rx_ready[c]),
      .rx_data  (rx_data[c]),
      .rx_flags (rx_flags[c]),
      .brk_o    (brk_out[c]),
      .mode1_q  (mode1_q[c]),
      .mode2_q  (mode2_q[c]),
      .csel_q   (csel_q[c])
    );
  end

  duart_shared u_shared (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_imr   (bus_wr && widx == SH_IRQ),
    .wr_set   (bus_wr && widx == SH_SET),
    .wr_clr   (bus_wr && widx == SH_CLR),
    .wdata    (bus_wdata),
    .txrdy    (txrdy),
    .rxrdy    (rxrdy),
    .isr      (isr),
    .irq      (irq),
    .out_port (out_port)
  );

  always_comb begin
    if (!is_shared)           bus_rdata = ch_rdata[bus_addr[5]];
    else if (widx == SH_IRQ)  bus_rdata = isr;
    else                      bus_rdata = '0;
  end

  // R14: a write to one channel leaves the other channel's mode registers alone
  a_r14_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_shared && bus_addr[5]) |=> ($stable(mode1_q[0]) && $stable(mode2_q[0])));
endmodule

// File: tb/duart_regif_test.sv
module duart_regif_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  logic [7:0] out_port;
  logic [1:0] tx_valid, rx_ready, brk_out;
  logic [1:0] tx_ready = '0, tx_busy = '0, rx_valid = '0;
  logic [1:0][7:0] tx_data, mode1_q, mode2_q, csel_q;
  logic [1:0][7:0] rx_data = '0;
  logic [1:0][2:0] rx_flags = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duart_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .out_port(out_port),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_busy(tx_busy),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_flags(rx_flags),
    .brk_out(brk_out), .mode1_q(mode1_q), .mode2_q(mode2_q), .csel_q(csel_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx_push(input int c, input logic [7:0] d, input logic [2:0] f);
    @(negedge clk);
    rx_valid[c] = 1'b1; rx_data[c] = d; rx_flags[c] = f;
    @(negedge clk);
    rx_valid[c] = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status A", 6'h04, 8'h00);
    rd_chk("R1 status B", 6'h24, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 out_port", out_port, 8'h00);
    chk("R1 tx_valid/brk", {4'd0, tx_valid, brk_out}, 8'h00);
    chk("R1 mode1 A", mode1_q[0], 8'h00);
    chk("R1 csel B", csel_q[1], 8'h00);
  endtask

  task automatic t_enable();
    wr(6'h08, 8'h05);
    rd_chk("R2 enabled status", 6'h04, 8'h0C);
    wr(6'h08, 8'h0A);
    rd_chk("R2 disabled status", 6'h04, 8'h00);
    wr(6'h08, 8'h0F);
    rd_chk("R2 disable wins", 6'h04, 8'h00);
    wr(6'h08, 8'h05);
    rd_chk("R2 re-enabled", 6'h04, 8'h0C);
  endtask

  task automatic t_tx();
    wr(6'h0C, 8'hA5);
    chk("R4 tx_valid", {7'd0, tx_valid[0]}, 8'h01);
    chk("R4 tx_data", tx_data[0], 8'hA5);
    rd_chk("R3 status full", 6'h04, 8'h00);
    wr(6'h0C, 8'h33);
    chk("R4 write while full ignored", tx_data[0], 8'hA5);
    chk("R4 still offered", {7'd0, tx_valid[0]}, 8'h01);
    tx_busy[0] = 1'b1;
    @(negedge clk); tx_ready[0] = 1'b1;
    @(negedge clk); tx_ready[0] = 1'b0;
    chk("R4 handshake drops valid", {7'd0, tx_valid[0]}, 8'h00);
    rd_chk("R3 ready not empty", 6'h04, 8'h04);
    tx_busy[0] = 1'b0;
    rd_chk("R3 ready and empty", 6'h04, 8'h0C);
  endtask

  task automatic t_txrst();
    wr(6'h0C, 8'h11);
    chk("R5 byte pending", {7'd0, tx_valid[0]}, 8'h01);
    wr(6'h08, 8'h30);
    chk("R5 reset drops byte", {7'd0, tx_valid[0]}, 8'h00);
    rd_chk("R5 status after reset", 6'h04, 8'h0C);
  endtask

  task automatic t_rx();
    rx_push(0, 8'h5A, 3'b001);
    rd_chk("R6 parity and ready", 6'h04, 8'h2D);
    rd_chk("R6 data", 6'h0C, 8'h5A);
    rd_chk("R6 cleared by read", 6'h04, 8'h0C);
    rx_push(0, 8'hC3, 3'b110);
    rd_chk("R6 break and framing", 6'h04, 8'hCD);
    rd_chk("R6 data 2", 6'h0C, 8'hC3);
    rd_chk("R6 cleared 2", 6'h04, 8'h0C);
  endtask

  task automatic t_ovr();
    rx_push(0, 8'h01, 3'b000);
    rx_push(0, 8'h02, 3'b000);
    rd_chk("R7 overrun set", 6'h04, 8'h1D);
    rd_chk("R7 first byte kept", 6'h0C, 8'h01);
    rd_chk("R7 overrun sticky", 6'h04, 8'h1C);
    wr(6'h08, 8'h20);
    rd_chk("R7 rx reset clears", 6'h04, 8'h0C);
  endtask

  task automatic t_rxdis();
    wr(6'h08, 8'h02);
    chk("R8 rx_ready low", {7'd0, rx_ready[0]}, 8'h00);
    rx_push(0, 8'h77, 3'b111);
    rd_chk("R8 byte ignored", 6'h04, 8'h0C);
    wr(6'h08, 8'h01);
    chk("R8 rx_ready back", {7'd0, rx_ready[0]}, 8'h01);
  endtask

  task automatic t_mode();
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h13);
    wr(6'h00, 8'h07);
    chk("R9 mode1", mode1_q[0], 8'h13);
    chk("R9 mode2", mode2_q[0], 8'h07);
    wr(6'h00, 8'h09);
    chk("R9 third write to mode2", mode2_q[0], 8'h09);
    chk("R9 mode1 kept", mode1_q[0], 8'h13);
    wr(6'h08, 8'h10);
    rd_chk("R9 read mode1", 6'h00, 8'h13);
    rd_chk("R9 read mode2", 6'h00, 8'h09);
    rd_chk("R9 stays on mode2", 6'h00, 8'h09);
  endtask

  task automatic t_csel();
    wr(6'h04, 8'h66);
    chk("R10 csel stored", csel_q[0], 8'h66);
    rd_chk("R10 status untouched", 6'h04, 8'h0C);
  endtask

  task automatic t_chb();
    wr(6'h20, 8'h44);
    chk("R14 B mode1", mode1_q[1], 8'h44);
    chk("R14 A mode1 kept", mode1_q[0], 8'h13);
    wr(6'h28, 8'h01);
    rd_chk("R14 B status", 6'h24, 8'h00);
    rd_chk("R14 A status kept", 6'h04, 8'h0C);
  endtask

  task automatic t_irq();
    rd_chk("R11 isr A tx", 6'h14, 8'h01);
    rx_push(1, 8'h3C, 3'b000);
    rd_chk("R11 isr B rx", 6'h14, 8'h21);
    wr(6'h14, 8'h10);
    chk("R11 masked source idle", {7'd0, irq}, 8'h00);
    wr(6'h14, 8'h20);
    chk("R11 B rx irq", {7'd0, irq}, 8'h01);
    rd_chk("R11 B data", 6'h2C, 8'h3C);
    chk("R11 irq drops", {7'd0, irq}, 8'h00);
    wr(6'h14, 8'h01);
    chk("R11 A tx irq", {7'd0, irq}, 8'h01);
    wr(6'h14, 8'h00);
    chk("R11 mask off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_opr();
    wr(6'h38, 8'h81);
    chk("R12 set", out_port, 8'h81);
    wr(6'h38, 8'h02);
    chk("R12 set keeps", out_port, 8'h83);
    wr(6'h3C, 8'h01);
    chk("R12 clear", out_port, 8'h82);
  endtask

  task automatic t_brk();
    wr(6'h08, 8'h60);
    chk("R13 break on", {6'd0, brk_out}, 8'h01);
    wr(6'h08, 8'h70);
    chk("R13 break off", {6'd0, brk_out}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_tx();
    t_txrst();
    t_rx();
    t_ovr();
    t_rxdis();
    t_mode();
    t_csel();
    t_chb();
    t_irq();
    t_opr();
    t_brk();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule